// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Stage with Hazard Scoreboard

This block is the issue point of a small pipeline that fetches and decodes two instructions per cycle. It feeds three execution units: an adder and a shifter that each take one cycle, and a multiplier that takes two cycles and cannot accept new work while busy. Each cycle the stage looks at the oldest two decoded instructions waiting upstream. It decides how many of them, zero, one or two, leave for the units. It keeps a record of every result still in flight, so it can refuse an instruction that would misuse a unit, read a stale register or let a slow older write land after a fast younger one.

Instructions always leave in program order. Results come back in whatever order the units finish. Two writeback ports are shared among the three units, and the oldest finished results win them. The upstream decoder keeps presenting an instruction until the matching take signal is high in a cycle, then shifts the next one in. Writeback outputs are registered. Take signals are combinational, so the upstream queue can advance in the same cycle.

Top module: `dual_issue_stage`

## Requirements
- R1: A synchronous active-high reset empties all tracking state. In the first cycle after reset, both writeback valid outputs are low and no register is considered pending.
- R2: The class field encodes the unit: 2'b00 is the adder, 2'b01 is the shifter, and 2'b1x is the multiplier. Adder and shifter latency is 1 and multiplier latency is 2. An instruction taken at clock edge k appears on a writeback port in the cycle after edge k+latency, for one cycle, unless port contention delays it.
- R3: Issue is in program order. Slot 1 is taken only in a cycle in which slot 0 is also taken, so an older instruction that stalls also holds back the younger one.
- R4: An instruction stalls when its unit still holds an unfinished or unwritten result. This includes a multiplier taken in the previous cycle. When both slots need the same unit, only slot 0 is taken.
- R5: An instruction stalls while either of its source registers is the destination of an in-flight result, up to and including the cycle in which that result is granted a port. Slot 1 also stalls when it reads the destination of slot 0.
- R6: An instruction stalls when its destination matches an in-flight result that would finish in the same cycle as the new one or later. A pair with equal destinations issues together only when the slot 0 latency is shorter than the slot 1 latency. The two writeback ports never carry the same register in one cycle.
- R7: A younger short-latency instruction may write back before an older multiply.
- R8: At most two results are written back per cycle. Port 0 carries the oldest finished result and port 1 the next oldest, and port 1 is never valid without port 0. A third finished result is held, and keeps its unit busy, until a later cycle.
- R9: A slot whose valid input is low is never taken, and it causes no hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Slot 0 (older) instruction present |
| s0_cls | input | 2 | Slot 0 unit class |
| s0_dst | input | RW | Slot 0 destination register |
| s0_sa | input | RW | Slot 0 first source register |
| s0_sb | input | RW | Slot 0 second source register |
| s1_vld | input | 1 | Slot 1 (younger) instruction present |
| s1_cls | input | 2 | Slot 1 unit class |
| s1_dst | input | RW | Slot 1 destination register |
| s1_sa | input | RW | Slot 1 first source register |
| s1_sb | input | RW | Slot 1 second source register |
| s0_take | output | 1 | Slot 0 issues at the coming edge |
| s1_take | output | 1 | Slot 1 issues at the coming edge |
| wb0_vld | output | 1 | Writeback port 0 carries a result |
| wb0_reg | output | RW | Register written through port 0 |
| wb1_vld | output | 1 | Writeback port 1 carries a result |
| wb1_reg | output | RW | Register written through port 1 |

## Verification
The assertions check the rules that can be judged within a cycle or two on every cycle:
- slot 1 never issues without slot 0;
- an issued pair never shares a unit, never reads its partner's destination, and never holds a forbidden equal destination;
- the multiplier stays blocked in the cycle after it is taken;
- port 1 is never used alone, and the two ports never carry the same register.

Only the bench's scenarios can show the rest:
- exact writeback timing;
- the age order across ports when three results finish together;
- the release of a held result;
- the point at which a read-after-write or write-after-write stall lifts.

The bench shows these by comparing every cycle against an in-order list model of the results in flight.

// File: rtl/dis_pkg.sv
package dis_pkg;

  typedef enum logic [1:0] {
    U_ADD = 2'd0,
    U_SHF = 2'd1,
    U_MUL = 2'd2
  } unit_e;

  localparam int NUM_UNITS = 3;

  function automatic unit_e unit_of(input logic [1:0] cls);
    if (cls[1])      return U_MUL;
    else if (cls[0]) return U_SHF;
    else             return U_ADD;
  endfunction

endpackage

// File: rtl/fu_slot.sv
// Tracks the single result a functional unit may hold.
module fu_slot #(
  parameter int RW   = 3,
  parameter int CW   = 2,
  parameter int SEQW = 4,
  parameter int LAT  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [RW-1:0]   ld_dst,
  input  logic [SEQW-1:0] ld_seq,
  input  logic            grant,
  output logic            vld,
  output logic [RW-1:0]   dst,
  output logic [CW-1:0]   rem,
  output logic [SEQW-1:0] seq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      dst <= '0;
      rem <= '0;
      seq <= '0;
    end else if (load) begin
      vld <= 1'b1;
      dst <= ld_dst;
      rem <= CW'(LAT);
      seq <= ld_seq;
    end else if (grant) begin
      vld <= 1'b0;
    end else if (vld && rem > CW'(1)) begin
      rem <= rem - CW'(1);
    end
  end

endmodule

// File: rtl/hazard_chk.sv
// Read-after-write and write-after-write detection for one issue slot.
module hazard_chk #(
  parameter int NU = 3,
  parameter int RW = 3,
  parameter int CW = 2
) (
  input  logic [NU-1:0] fvld,
  input  logic [RW-1:0] fdst [NU],
  input  logic [CW-1:0] frem [NU],
  input  logic [NU-1:0] gnt,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] sa,
  input  logic [RW-1:0] sb,
  input  logic [CW-1:0] lat,
  output logic          raw_hit,
  output logic          waw_hit
);

  logic [CW-1:0] eff [NU];

  always_comb begin
    raw_hit = 1'b0;
    waw_hit = 1'b0;
    for (int i = 0; i < NU; i++) begin
      // cycles after the coming edge until this entry finishes
      eff[i] = (frem[i] > CW'(1)) ? frem[i] - CW'(1) : CW'(1);
      if (fvld[i] && (fdst[i] == sa || fdst[i] == sb))
        raw_hit = 1'b1;
      if (fvld[i] && !gnt[i] && fdst[i] == dst && eff[i] >= lat)
        waw_hit = 1'b1;
    end
  end

endmodule

// File: rtl/wb_pick.sv
// Grants the two writeback ports to the oldest finished results.
module wb_pick #(
  parameter int NU   = 3,
  parameter int SEQW = 4,
  parameter int IW   = 2
) (
  input  logic [NU-1:0]   done,
  input  logic [SEQW-1:0] seq [NU],
  output logic [NU-1:0]   gnt,
  output logic            p0_vld,
  output logic [IW-1:0]   p0_idx,
  output logic            p1_vld,
  output logic [IW-1:0]   p1_idx
);

  function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return d[SEQW-1];
  endfunction

  always_comb begin
    int rk;
    gnt    = '0;
    p0_vld = 1'b0;
    p0_idx = '0;
    p1_vld = 1'b0;
    p1_idx = '0;
    for (int i = 0; i < NU; i++) begin
      rk = 0;
      for (int j = 0; j < NU; j++)
        if (j != i && done[j] && older(seq[j], seq[i]))
          rk = rk + 1;
      gnt[i] = done[i] && (rk < 2);
      if (done[i] && rk == 0) begin
        p0_vld = 1'b1;
        p0_idx = IW'(i);
      end
      if (done[i] && rk == 1) begin
        p1_vld = 1'b1;
        p1_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dual_issue_stage.sv
module dual_issue_stage
  import dis_pkg::*;
#(
  parameter int RW      = 3,
  parameter int LAT_ADD = 1,
  parameter int LAT_SHF = 1,
  parameter int LAT_MUL = 2,
  parameter int SEQW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s0_vld,
  input  logic [1:0]    s0_cls,
  input  logic [RW-1:0] s0_dst,
  input  logic [RW-1:0] s0_sa,
  input  logic [RW-1:0] s0_sb,
  input  logic          s1_vld,
  input  logic [1:0]    s1_cls,
  input  logic [RW-1:0] s1_dst,
  input  logic [RW-1:0] s1_sa,
  input  logic [RW-1:0] s1_sb,
  output logic          s0_take,
  output logic          s1_take,
  output logic          wb0_vld,
  output logic [RW-1:0] wb0_reg,
  output logic          wb1_vld,
  output logic [RW-1:0] wb1_reg
);

  localparam int NU   = NUM_UNITS;
  localparam int LMAX = (LAT_MUL > LAT_ADD ? (LAT_MUL > LAT_SHF ? LAT_MUL : LAT_SHF)
                                           : (LAT_ADD > LAT_SHF ? LAT_ADD : LAT_SHF));
  localparam int CW   = $clog2(LMAX + 1);
  localparam int IW   = $clog2(NU);

  function automatic logic [CW-1:0] lat_of(input unit_e u);
    case (u)
      U_ADD:   return CW'(LAT_ADD);
      U_SHF:   return CW'(LAT_SHF);
      default: return CW'(LAT_MUL);
    endcase
  endfunction

  logic [NU-1:0]   f_vld, f_done, gnt, free_u, load;
  logic [RW-1:0]   f_dst  [NU];
  logic [CW-1:0]   f_rem  [NU];
  logic [SEQW-1:0] f_seq  [NU];
  logic [RW-1:0]   ld_dst [NU];
  logic [SEQW-1:0] ld_seq [NU];
  logic [SEQW-1:0] seq_q;

  unit_e         u0, u1;
  logic [CW-1:0] l0, l1;
  logic [RW-1:0] sl_dst [2];
  logic [RW-1:0] sl_sa  [2];
  logic [RW-1:0] sl_sb  [2];
  logic [CW-1:0] sl_lat [2];
  logic [1:0]    raw, waw;
  logic          ok0, ok1, pair_ok;

  logic          p0_vld, p1_vld;
  logic [IW-1:0] p0_idx, p1_idx;

  genvar gi;
  generate
    for (gi = 0; gi < NU; gi++) begin : g_fu
      localparam int LAT = (gi == 0) ? LAT_ADD : (gi == 1) ? LAT_SHF : LAT_MUL;
      fu_slot #(.RW(RW), .CW(CW), .SEQW(SEQW), .LAT(LAT)) u_fu (
        .clk    (clk),
        .rst    (rst),
        .load   (load[gi]),
        .ld_dst (ld_dst[gi]),
        .ld_seq (ld_seq[gi]),
        .grant  (gnt[gi]),
        .vld    (f_vld[gi]),
        .dst    (f_dst[gi]),
        .rem    (f_rem[gi]),
        .seq    (f_seq[gi])
      );
      assign f_done[gi] = f_vld[gi] && (f_rem[gi] == CW'(1));
    end
  endgenerate

  wb_pick #(.NU(NU), .SEQW(SEQW), .IW(IW)) u_pick (
    .done   (f_done),
    .seq    (f_seq),
    .gnt    (gnt),
    .p0_vld (p0_vld),
    .p0_idx (p0_idx),
    .p1_vld (p1_vld),
    .p1_idx (p1_idx)
  );

  always_comb begin
    u0 = unit_of(s0_cls);
    u1 = unit_of(s1_cls);
    l0 = lat_of(u0);
    l1 = lat_of(u1);
    sl_dst[0] = s0_dst; sl_sa[0] = s0_sa; sl_sb[0] = s0_sb; sl_lat[0] = l0;
    sl_dst[1] = s1_dst; sl_sa[1] = s1_sa; sl_sb[1] = s1_sb; sl_lat[1] = l1;
  end

  generate
    for (gi = 0; gi < 2; gi++) begin : g_hz
      hazard_chk #(.NU(NU), .RW(RW), .CW(CW)) u_hz (
        .fvld    (f_vld),
        .fdst    (f_dst),
        .frem    (f_rem),
        .gnt     (gnt),
        .dst     (sl_dst[gi]),
        .sa      (sl_sa[gi]),
        .sb      (sl_sb[gi]),
        .lat     (sl_lat[gi]),
        .raw_hit (raw[gi]),
        .waw_hit (waw[gi])
      );
    end
  endgenerate

  // a unit is free when empty or when its result leaves at this edge
  assign free_u = ~f_vld | gnt;

  always_comb begin
    ok0     = s0_vld && free_u[u0] && !raw[0] && !waw[0];
    pair_ok = (u1 != u0) && (s1_sa != s0_dst) && (s1_sb != s0_dst)
              && !((s1_dst == s0_dst) && (l0 >= l1));
    ok1     = ok0 && s1_vld && free_u[u1] && !raw[1] && !waw[1] && pair_ok;
    for (int i = 0; i < NU; i++) begin
      load[i]   = (ok0 && int'(u0) == i) || (ok1 && int'(u1) == i);
      ld_dst[i] = (ok0 && int'(u0) == i) ? s0_dst : s1_dst;
      ld_seq[i] = (ok0 && int'(u0) == i) ? seq_q : seq_q + SEQW'(1);
    end
  end

  assign s0_take = ok0;
  assign s1_take = ok1;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= '0;
      wb0_vld <= 1'b0;
      wb0_reg <= '0;
      wb1_vld <= 1'b0;
      wb1_reg <= '0;
    end else begin
      seq_q   <= seq_q + SEQW'(ok0) + SEQW'(ok1);
      wb0_vld <= p0_vld;
      wb0_reg <= f_dst[p0_idx];
      wb1_vld <= p1_vld;
      wb1_reg <= f_dst[p1_idx];
    end
  end

endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
  parameter int RW      = 3,
  parameter int LAT_ADD = 1,
  parameter int LAT_SHF = 1,
  parameter int LAT_MUL = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          s0_vld,
  input logic [1:0]    s0_cls,
  input logic [RW-1:0] s0_dst,
  input logic          s1_vld,
  input logic [1:0]    s1_cls,
  input logic [RW-1:0] s1_dst,
  input logic [RW-1:0] s1_sa,
  input logic [RW-1:0] s1_sb,
  input logic          s0_take,
  input logic          s1_take,
  input logic          wb0_vld,
  input logic [RW-1:0] wb0_reg,
  input logic          wb1_vld,
  input logic [RW-1:0] wb1_reg
);

  function automatic int lat_c(input logic [1:0] c);
    if (c[1])      return LAT_MUL;
    else if (c[0]) return LAT_SHF;
    else           return LAT_ADD;
  endfunction

  logic both;
  assign both = s0_take && s1_take;

  a_r3_in_order: assert property (@(posedge clk) disable iff (rst)
    s1_take |-> s0_take);

  a_r9_valid_only: assert property (@(posedge clk) disable iff (rst)
    (s0_take |-> s0_vld) and (s1_take |-> s1_vld));

  a_r4_pair_units: assert property (@(posedge clk) disable iff (rst)
    both |-> (s0_cls[1] != s1_cls[1]) || (!s0_cls[1] && s0_cls[0] != s1_cls[0]));

  a_r4_mul_busy: assert property (@(posedge clk) disable iff (rst)
    (s0_take && s0_cls[1]) || (s1_take && s1_cls[1])
      |=> !(s0_take && s0_cls[1]) && !(s1_take && s1_cls[1]));

  a_r5_pair_raw: assert property (@(posedge clk) disable iff (rst)
    both |-> (s1_sa != s0_dst) && (s1_sb != s0_dst));

  a_r6_pair_waw: assert property (@(posedge clk) disable iff (rst)
    both && (s0_dst == s1_dst) |-> lat_c(s0_cls) < lat_c(s1_cls));

  a_r6_ports_distinct: assert property (@(posedge clk) disable iff (rst)
    wb0_vld && wb1_vld |-> wb0_reg != wb1_reg);

  a_r8_port_order: assert property (@(posedge clk) disable iff (rst)
    wb1_vld |-> wb0_vld);

endmodule

bind dual_issue_stage dis_checker #(
  .RW(RW), .LAT_ADD(LAT_ADD), .LAT_SHF(LAT_SHF), .LAT_MUL(LAT_MUL)
) u_chk (
  .clk(clk), .rst(rst),
  .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dst(s0_dst),
  .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_sa(s1_sa), .s1_sb(s1_sb),
  .s0_take(s0_take), .s1_take(s1_take),
  .wb0_vld(wb0_vld), .wb0_reg(wb0_reg), .wb1_vld(wb1_vld), .wb1_reg(wb1_reg)
);

// File: tb/tb_dual_issue_stage.sv
`timescale 1ns/1ps
module tb_dual_issue_stage;

  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s0_vld, s1_vld;
  logic [1:0] s0_cls, s1_cls;
  logic [RW-1:0] s0_dst, s0_sa, s0_sb, s1_dst, s1_sa, s1_sb;
  logic s0_take, s1_take, wb0_vld, wb1_vld;
  logic [RW-1:0] wb0_reg, wb1_reg;

  always #5 clk = ~clk;

  dual_issue_stage #(.RW(RW)) dut (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_sa(s0_sa), .s0_sb(s0_sb),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_sa(s1_sa), .s1_sb(s1_sb),
    .s0_take(s0_take), .s1_take(s1_take),
    .wb0_vld(wb0_vld), .wb0_reg(wb0_reg), .wb1_vld(wb1_vld), .wb1_reg(wb1_reg)
  );

  typedef struct { int dst; int unit; int rem; } fl_t;
  typedef struct { int c; int d; int a; int b; } ins_t;

  fl_t   q[$];
  bit    g[$];
  ins_t  pend[$];
  int    ewb_v[2], ewb_r[2];
  bit    e0, e1;
  int    tests = 0, fails = 0;
  bit    finished = 0;
  string tag = "R1";

  function automatic int unit_of(int c);
    return (c >= 2) ? 2 : ((c == 1) ? 1 : 0);
  endfunction
  function automatic int lat(int u);
    return (u == 2) ? 2 : 1;
  endfunction

  function automatic bit unit_free(int u);
    foreach (q[k]) if (q[k].unit == u && !g[k]) return 0;
    return 1;
  endfunction
  function automatic bit raw_hit(int r);
    foreach (q[k]) if (q[k].dst == r) return 1;
    return 0;
  endfunction
  function automatic bit waw_hit(int d, int l);
    int eff;
    foreach (q[k]) begin
      eff = (q[k].rem > 1) ? q[k].rem - 1 : 1;
      if (q[k].dst == d && !g[k] && eff >= l) return 1;
    end
    return 0;
  endfunction

  task automatic check(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(int k, bit v, int c, int d, int a, int b);
    if (k == 0) begin
      s0_vld = v; s0_cls = c[1:0]; s0_dst = d[RW-1:0]; s0_sa = a[RW-1:0]; s0_sb = b[RW-1:0];
    end else begin
      s1_vld = v; s1_cls = c[1:0]; s1_dst = d[RW-1:0]; s1_sa = a[RW-1:0]; s1_sb = b[RW-1:0];
    end
  endtask

  task automatic cyc();
    int nd, u0, u1, l0, l1, n;
    fl_t nq[$];
    fl_t e;
    @(negedge clk);
    nd = 0;
    g.delete();
    foreach (q[k]) begin
      g.push_back(q[k].rem == 1 && nd < 2);
      if (q[k].rem == 1 && nd < 2) nd++;
    end
    u0 = unit_of(int'(s0_cls)); u1 = unit_of(int'(s1_cls));
    l0 = lat(u0); l1 = lat(u1);
    e0 = s0_vld && unit_free(u0) && !raw_hit(int'(s0_sa)) && !raw_hit(int'(s0_sb))
         && !waw_hit(int'(s0_dst), l0);
    e1 = e0 && s1_vld && u1 != u0 && unit_free(u1)
         && !raw_hit(int'(s1_sa)) && !raw_hit(int'(s1_sb)) && !waw_hit(int'(s1_dst), l1)
         && s1_sa != s0_dst && s1_sb != s0_dst && !(s1_dst == s0_dst && l0 >= l1);
    check("s0_take", int'(s0_take), int'(e0));
    check("s1_take", int'(s1_take), int'(e1));
    check("wb0", wb0_vld ? 100 + int'(wb0_reg) : 0, ewb_v[0] ? 100 + ewb_r[0] : 0);
    check("wb1", wb1_vld ? 100 + int'(wb1_reg) : 0, ewb_v[1] ? 100 + ewb_r[1] : 0);
    @(posedge clk);
    ewb_v[0] = 0; ewb_v[1] = 0; n = 0;
    foreach (q[k]) begin
      if (g[k]) begin
        ewb_v[n] = 1; ewb_r[n] = q[k].dst; n++;
      end else begin
        e = q[k];
        if (e.rem > 1) e.rem--;
        nq.push_back(e);
      end
    end
    if (e0) begin e.dst = int'(s0_dst); e.unit = u0; e.rem = l0; nq.push_back(e); end
    if (e1) begin e.dst = int'(s1_dst); e.unit = u1; e.rem = l1; nq.push_back(e); end
    q = nq;
    #1;
  endtask

  task automatic idle(int n);
    put(0, 0, 0, 0, 0, 0);
    put(1, 0, 0, 0, 0, 0);
    repeat (n) cyc();
  endtask

  initial begin
    ewb_v[0] = 0; ewb_v[1] = 0; ewb_r[0] = 0; ewb_r[1] = 0;
    put(0, 0, 0, 0, 0, 0);
    put(1, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: clean state after reset, then an instruction issues at once
    tag = "R1"; idle(1);
    put(0, 1, 0, 1, 2, 3); cyc(); idle(2);

    // R9: invalid slot 0 blocks everything
    tag = "R9"; put(0, 0, 0, 1, 2, 3); put(1, 1, 1, 4, 5, 6); cyc(); idle(1);

    // R2: shifter latency, multiplier latency (class 2'b11)
    tag = "R2"; put(0, 1, 1, 2, 0, 0); cyc(); idle(2);
    put(0, 1, 3, 6, 0, 0); cyc(); idle(3);

    // R7: younger adder completes before older multiply
    tag = "R7"; put(0, 1, 2, 1, 2, 3); put(1, 1, 0, 4, 5, 6); cyc(); idle(3);

    // R4: multiplier busy, same-unit pair
    tag = "R4"; put(0, 1, 2, 1, 2, 3); cyc();
    put(0, 1, 2, 2, 3, 4); cyc(); cyc(); idle(3);
    put(0, 1, 0, 1, 0, 0); put(1, 1, 0, 2, 0, 0); cyc(); idle(2);

    // R5: read after write on an in-flight result and inside a pair
    tag = "R5"; put(0, 1, 0, 3, 0, 0); cyc();
    put(0, 1, 0, 5, 3, 0); cyc(); cyc(); idle(2);
    put(0, 1, 0, 6, 0, 0); put(1, 1, 1, 7, 6, 0); cyc(); idle(2);

    // R6: write after write with a slower older writer, and pairs
    tag = "R6"; put(0, 1, 2, 5, 0, 0); cyc();
    put(0, 1, 0, 5, 1, 1); cyc(); cyc(); idle(3);
    put(0, 1, 0, 7, 1, 1); put(1, 1, 2, 7, 1, 1); cyc(); idle(3);
    put(0, 1, 2, 7, 1, 1); put(1, 1, 0, 7, 1, 1); cyc(); idle(3);

    // R8: three results finish together
    tag = "R8"; put(0, 1, 2, 1, 0, 0); cyc();
    put(0, 1, 0, 2, 0, 0); put(1, 1, 1, 3, 0, 0); cyc(); idle(4);

    // R3: stalled older instruction holds back an independent younger one
    tag = "R3"; put(0, 1, 2, 1, 0, 0); cyc();
    put(0, 1, 0, 4, 1, 0); put(1, 1, 1, 5, 0, 0); cyc(); idle(3);

    // R3: random program stream with in-order consumption
    tag = "R3";
    for (int it = 0; it < 600; it++) begin
      ins_t x;
      while (pend.size() < 2) begin
        x.c = int'($urandom % 4); x.d = int'($urandom % 8);
        x.a = int'($urandom % 8); x.b = int'($urandom % 8);
        pend.push_back(x);
      end
      put(0, 1, pend[0].c, pend[0].d, pend[0].a, pend[0].b);
      put(1, ($urandom % 5) != 0, pend[1].c, pend[1].d, pend[1].a, pend[1].b);
      cyc();
      if (e0) void'(pend.pop_front());
      if (e1) void'(pend.pop_front());
    end
    idle(4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule